// File: doc/BRIEF.md
# Register-Window SPI Command Engine

This block is an SPI master controlled through a small window of eight byte-wide host registers. The host first loads an opcode, up to three address bytes and one trailing data byte into their own registers. It then writes a control byte that selects how many bytes go out, how many come back and which of two clock rates to use. That control write also starts the transfer. The engine frames the transfer with chip select, shifts the selected bytes out MSB first in SPI mode 0, and captures up to three response bytes. While it works, bit 7 of the control register reads as 1.

Transmit lengths are limited to 1, 2, 4 or 5 bytes, picked by a 2-bit code. The three address bytes sit in the register window in the reverse of their wire order, so offset 4 holds the byte that goes out first. Receive length runs from zero to three bytes. The two clock rates are obtained by dividing the system clock: each SCK half period lasts a parameterised number of system cycles.

Top module: `spi_cmd_engine`

## Requirements
- R1: After a synchronous reset, spi_cs_n is 1, spi_sck is 0 and spi_mosi is 0, and all eight register offsets read 0x00.
- R2: A host write to offset 0 starts a transfer only when the engine is idle and data bits [6:4] equal 3'b100 or 3'b101. Bit 4 = 1 selects the fast rate (half period FAST_HALF cycles) and bit 4 = 0 selects the slow rate (half period SLOW_HALF cycles). Any other value of bits [6:4] leaves chip select high and changes no register. From the cycle after an accepted start, bit 7 of offset 0 reads 1 until the transfer ends.
- R3: The write code in control bits [1:0] selects the bytes sent, each MSB first. Code 0 sends the opcode (offset 1). Code 1 sends the opcode, then the data byte (offset 7). Code 2 sends the opcode, then offsets 4, 3 and 2. Code 3 sends the opcode, then offsets 4, 3 and 2, then offset 7.
- R4: Control bits [3:2] give the receive count N (0 to 3), clocked after the transmit bytes with spi_mosi held 0. The k-th received byte is readable at offset 5+k once the engine is idle. Receive slots at or beyond N keep their earlier contents.
- R5: SPI mode 0 timing applies. SCK idles low and each bit spends HALF system cycles low, then HALF cycles high. The engine samples MISO on the rising edge and changes MOSI on the falling edge. spi_cs_n is low for exactly 2*HALF*8*(bytes sent + N) cycles, and busy clears in the same cycle that chip select rises.
- R6: A start written while busy is ignored and the latched command is unchanged. Writes to offsets 1 to 4 and 7 during a transfer do not alter the bytes being sent.
- R7: Offset 0 reads {busy, 3'b000, receive count, write code} of the last accepted command. Offsets 1 to 4 read back the last values written. Offsets 5, 6 and 7 read receive slots 0, 1 and 2, not the written data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe for reg_addr/reg_wdata |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data of the register at reg_addr (combinational) |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with SLOW_HALF = 3 and FAST_HALF = 1. With these values the longest frame lasts under 400 cycles, so the bench can sweep all four write codes, all four receive counts and both rates: 32 transfers, each with its own register contents and device response. Cycle counts for chip select and the number of SCK rising edges are worked out exactly from the half periods. The small dividers also keep short the window in which the bench writes a second start and new payload bytes while a transfer is running.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int MAX_TX_BYTES = 5;
    localparam int MAX_RX_BYTES = 3;
    localparam int TX_BITS      = 8 * MAX_TX_BYTES;
    localparam int RX_BITS      = 8 * MAX_RX_BYTES;
    localparam int FRAME_CNT_W  = $clog2(8 * (MAX_TX_BYTES + MAX_RX_BYTES) + 1);

    // register offsets whose placement the transfer order depends on
    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_OP   = 3'd1;
    localparam logic [2:0] OFS_A_LO = 3'd2;
    localparam logic [2:0] OFS_A_MD = 3'd3;
    localparam logic [2:0] OFS_A_HI = 3'd4;
    localparam logic [2:0] OFS_RX0  = 3'd5;
    localparam logic [2:0] OFS_RX1  = 3'd6;
    localparam logic [2:0] OFS_DATA = 3'd7;

    localparam logic [2:0] GO_SLOW = 3'b100;
    localparam logic [2:0] GO_FAST = 3'b101;

    typedef enum logic [1:0] {
        SEND_OP          = 2'd0,
        SEND_OP_DATA     = 2'd1,
        SEND_OP_ADDR     = 2'd2,
        SEND_OP_ADDR_DAT = 2'd3
    } send_code_e;

    typedef struct packed {
        logic       fast;
        logic [1:0] rd_cnt;
        send_code_e code;
    } cmd_t;

    function automatic logic is_go(input logic [7:0] w);
        return (w[6:4] == GO_SLOW) || (w[6:4] == GO_FAST);
    endfunction

    function automatic int tx_bytes(input send_code_e c);
        case (c)
            SEND_OP:      return 1;
            SEND_OP_DATA: return 2;
            SEND_OP_ADDR: return 4;
            default:      return 5;
        endcase
    endfunction

    function automatic logic [FRAME_CNT_W-1:0] frame_bits(input send_code_e c,
                                                          input logic [1:0] rd);
        return FRAME_CNT_W'(8 * (tx_bytes(c) + int'(rd)));
    endfunction

    // bytes left-justified in wire order; unused tail is zero so MOSI idles low
    function automatic logic [TX_BITS-1:0] pack_tx(input send_code_e c,
                                                   input logic [7:0] op,
                                                   input logic [7:0] a_hi,
                                                   input logic [7:0] a_md,
                                                   input logic [7:0] a_lo,
                                                   input logic [7:0] dat);
        case (c)
            SEND_OP:      return {op, 32'h0};
            SEND_OP_DATA: return {op, dat, 24'h0};
            SEND_OP_ADDR: return {op, a_hi, a_md, a_lo, 8'h0};
            default:      return {op, a_hi, a_md, a_lo, dat};
        endcase
    endfunction

    // k-th received byte of an rd-byte response held right-justified in sr
    function automatic logic [7:0] rx_pick(input logic [RX_BITS-1:0] sr,
                                           input int rd, input int k);
        return 8'(sr >> (8 * (rd - 1 - k)));
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_cmd_pkg::*;
#(
    parameter int SLOW_HALF = 4,
    parameter int FAST_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW   = (MAXH < 2) ? 1 : $clog2(MAXH + 1);

    logic [CW-1:0] hcnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(FAST_HALF) : CW'(SLOW_HALF);
    assign tick = run && (hcnt == lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
        end else if (tick) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + CW'(1);
        end
    end

    assert_half_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (hcnt < lim))
        else $error("half-period counter beyond its limit");

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_cmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [TX_BITS-1:0]     tx_load,
    input  logic [FRAME_CNT_W-1:0] nbits,
    input  logic                   tick,
    input  logic                   miso,
    output logic                   active,
    output logic                   sck,
    output logic                   cs_n,
    output logic                   mosi,
    output logic                   finish,
    output logic [RX_BITS-1:0]     rx_sr
);
    logic [TX_BITS-1:0]     tx_sr;
    logic [FRAME_CNT_W-1:0] left;

    assign mosi   = tx_sr[TX_BITS-1];
    assign finish = active && tick && sck && (left == FRAME_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sck    <= 1'b0;
            cs_n   <= 1'b1;
            tx_sr  <= '0;
            rx_sr  <= '0;
            left   <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            cs_n   <= 1'b0;
            sck    <= 1'b0;
            tx_sr  <= tx_load;
            left   <= nbits;
        end else if (active && tick) begin
            if (!sck) begin
                sck   <= 1'b1;
                rx_sr <= {rx_sr[RX_BITS-2:0], miso};
            end else begin
                sck   <= 1'b0;
                tx_sr <= {tx_sr[TX_BITS-2:0], 1'b0};
                left  <= left - FRAME_CNT_W'(1);
                if (left == FRAME_CNT_W'(1)) begin
                    active <= 1'b0;
                    cs_n   <= 1'b1;
                end
            end
        end
    end

    assert_sck_inside_frame_R5: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n)
        else $error("SCK high with chip select released");

    assert_sck_holds_between_ticks_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> $stable(sck))
        else $error("SCK moved without a half-period tick");

    assert_finish_closes_frame_R5: assert property (@(posedge clk) disable iff (rst)
        finish |=> (cs_n && !sck && !active))
        else $error("frame not closed after last bit");

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [2:0]             addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic                   busy,
    input  logic                   finish,
    input  logic [RX_BITS-1:0]     rx_sr,
    output logic                   start,
    output logic [TX_BITS-1:0]     tx_load,
    output logic [FRAME_CNT_W-1:0] nbits,
    output logic                   fast
);
    cmd_t       cmd_q;
    cmd_t       cmd_new;
    logic [7:0] op_q;
    logic [7:0] a_lo_q, a_md_q, a_hi_q;
    logic [7:0] dat_q;
    logic [7:0] rx_q [MAX_RX_BYTES];

    assign cmd_new = '{fast: wdata[4], rd_cnt: wdata[3:2], code: send_code_e'(wdata[1:0])};
    assign start   = wr && (addr == OFS_CTRL) && is_go(wdata) && !busy;
    assign tx_load = pack_tx(cmd_new.code, op_q, a_hi_q, a_md_q, a_lo_q, dat_q);
    assign nbits   = frame_bits(cmd_new.code, cmd_new.rd_cnt);
    assign fast    = cmd_q.fast;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            op_q   <= '0;
            a_lo_q <= '0;
            a_md_q <= '0;
            a_hi_q <= '0;
            dat_q  <= '0;
        end else begin
            if (start) begin
                cmd_q <= cmd_new;
            end
            if (wr) begin
                case (addr)
                    OFS_OP:   op_q   <= wdata;
                    OFS_A_LO: a_lo_q <= wdata;
                    OFS_A_MD: a_md_q <= wdata;
                    OFS_A_HI: a_hi_q <= wdata;
                    OFS_DATA: dat_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar k = 0; k < MAX_RX_BYTES; k++) begin : g_rx_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                rx_q[k] <= '0;
            end else if (finish && (k < int'(cmd_q.rd_cnt))) begin
                rx_q[k] <= rx_pick(rx_sr, int'(cmd_q.rd_cnt), k);
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = {busy, 3'b000, cmd_q.rd_cnt, cmd_q.code};
            OFS_OP:   rdata = op_q;
            OFS_A_LO: rdata = a_lo_q;
            OFS_A_MD: rdata = a_md_q;
            OFS_A_HI: rdata = a_hi_q;
            OFS_RX0:  rdata = rx_q[0];
            OFS_RX1:  rdata = rx_q[1];
            default:  rdata = rx_q[2];
        endcase
    end

    assert_start_ignored_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && wr && (addr == OFS_CTRL)) |=> $stable(cmd_q))
        else $error("command changed by a write during a transfer");

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SLOW_HALF = 4,
    parameter int FAST_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic                   start;
    logic [TX_BITS-1:0]     tx_load;
    logic [FRAME_CNT_W-1:0] nbits;
    logic                   fast;
    logic                   tick;
    logic                   active;
    logic                   finish;
    logic [RX_BITS-1:0]     rx_sr;

    spi_cmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .busy    (active),
        .finish  (finish),
        .rx_sr   (rx_sr),
        .start   (start),
        .tx_load (tx_load),
        .nbits   (nbits),
        .fast    (fast)
    );

    spi_sck_gen #(
        .SLOW_HALF (SLOW_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_sck (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .fast (fast),
        .tick (tick)
    );

    spi_bit_engine u_bits (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tx_load (tx_load),
        .nbits   (nbits),
        .tick    (tick),
        .miso    (spi_miso),
        .active  (active),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .finish  (finish),
        .rx_sr   (rx_sr)
    );

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_H = 3;
    localparam int FAST_H = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    spi_cmd_engine #(.SLOW_HALF(SLOW_H), .FAST_HALF(FAST_H)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // device model: captures MOSI on SCK rise, advances MISO after SCK fall
    logic [63:0] slv_out = '0;
    logic [63:0] slv_sh = '0;
    logic [63:0] mosi_cap = '0;
    int nrise = 0;
    int cs_cycles = 0;
    int total_low = 0;
    logic prev_cs = 1'b1;
    logic prev_sck = 1'b0;

    initial forever begin
        @(negedge clk);
        if (prev_cs && !spi_cs_n) begin
            slv_sh = slv_out; nrise = 0; mosi_cap = '0; cs_cycles = 0;
        end
        if (spi_cs_n === 1'b0) begin
            cs_cycles++; total_low++;
        end
        if (!prev_sck && spi_sck) begin
            mosi_cap = {mosi_cap[62:0], spi_mosi}; nrise++;
        end
        if (prev_sck && !spi_sck) slv_sh = slv_sh << 1;
        spi_miso = slv_sh[63];
        prev_cs = spi_cs_n;
        prev_sck = spi_sck;
    end

    task automatic run_xfer(input int idx, input logic [1:0] code, input logic [1:0] rdn,
                            input bit fast, input bit meddle);
        logic [7:0] op, a_lo, a_md, a_hi, dat, v;
        logic [7:0] r [3];
        logic [7:0] old [3];
        logic [7:0] txb [5];
        logic [63:0] expv, sb;
        int ntx, nb, half, guard;
        op = 8'(idx * 37 + 11); a_lo = 8'(idx * 13 + 200); a_md = 8'(idx * 59 + 7);
        a_hi = 8'(idx * 101 + 90); dat = 8'(idx * 23 + 150);
        wr(3'd1, op); wr(3'd2, a_lo); wr(3'd3, a_md); wr(3'd4, a_hi); wr(3'd7, dat);
        rd(3'd1, v); check(v == op, "R7 opcode readback", 64'(v), 64'(op));
        rd(3'd2, v); check(v == a_lo, "R7 offset2 readback", 64'(v), 64'(a_lo));
        rd(3'd3, v); check(v == a_md, "R7 offset3 readback", 64'(v), 64'(a_md));
        rd(3'd4, v); check(v == a_hi, "R7 offset4 readback", 64'(v), 64'(a_hi));
        case (code)
            2'd0: begin ntx = 1; txb[0] = op; end
            2'd1: begin ntx = 2; txb[0] = op; txb[1] = dat; end
            2'd2: begin ntx = 4; txb[0] = op; txb[1] = a_hi; txb[2] = a_md; txb[3] = a_lo; end
            default: begin ntx = 5; txb[0] = op; txb[1] = a_hi; txb[2] = a_md;
                           txb[3] = a_lo; txb[4] = dat; end
        endcase
        nb = 8 * (ntx + int'(rdn));
        half = fast ? FAST_H : SLOW_H;
        for (int k = 0; k < 3; k++) begin
            r[k] = 8'(idx * 29 + k * 71 + 5);
            rd(3'(5 + k), old[k]);
        end
        sb = '0;
        for (int k = 0; k < ntx; k++) sb = {sb[55:0], 8'hE7 ^ 8'(k)};
        for (int k = 0; k < int'(rdn); k++) sb = {sb[55:0], r[k]};
        slv_out = sb << (64 - nb);
        expv = '0;
        for (int k = 0; k < ntx; k++) expv = {expv[55:0], txb[k]};
        for (int k = 0; k < int'(rdn); k++) expv = {expv[55:0], 8'h00};

        wr(3'd0, {1'b0, 2'b10, fast, rdn, code});
        rd(3'd0, v);
        check(v == {1'b1, 3'b000, rdn, code}, "R2 busy set and command latched",
              64'(v), 64'({1'b1, 3'b000, rdn, code}));
        if (meddle) begin
            repeat (4) @(negedge clk);
            wr(3'd0, 8'h53);
            wr(3'd1, ~op); wr(3'd4, ~a_hi); wr(3'd7, ~dat);
            rd(3'd0, v);
            check(v == {1'b1, 3'b000, rdn, code}, "R6 start during busy ignored",
                  64'(v), 64'({1'b1, 3'b000, rdn, code}));
        end
        guard = 0;
        do begin
            rd(3'd0, v); guard++;
        end while (v[7] && guard < 5000);
        check(v[7] == 1'b0, "R2 busy clears", 64'(v[7]), 64'(0));
        check(nrise == nb, "R5 SCK rising edges", 64'(nrise), 64'(nb));
        check(cs_cycles == 2 * half * nb, "R5 chip select low cycles",
              64'(cs_cycles), 64'(2 * half * nb));
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R5 idle lines after frame",
              64'({spi_cs_n, spi_sck}), 64'(2));
        check(mosi_cap == expv, meddle ? "R6 snapshot bytes sent" : "R3 R4 MOSI stream",
              mosi_cap, expv);
        for (int k = 0; k < 3; k++) begin
            rd(3'(5 + k), v);
            if (k < int'(rdn))
                check(v == r[k], "R4 received byte slot", 64'(v), 64'(r[k]));
            else
                check(v == old[k], "R4 unused slot kept", 64'(v), 64'(old[k]));
        end
    endtask

    initial begin
        logic [7:0] v, base;
        int idx, low0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0,
              "R1 reset line levels", 64'({spi_cs_n, spi_sck, spi_mosi}), 64'(4));
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check(v == 8'h00, "R1 reset register value", 64'(v), 64'(0));
        end

        idx = 0;
        for (int c = 0; c < 4; c++)
            for (int n = 0; n < 4; n++)
                for (int f = 0; f < 2; f++) begin
                    run_xfer(idx, 2'(c), 2'(n), f[0], 1'b0);
                    idx++;
                end

        run_xfer(90, 2'd3, 2'd3, 1'b0, 1'b1);
        run_xfer(91, 2'd2, 2'd1, 1'b1, 1'b1);

        // R2: values of bits [6:4] other than 100/101 do not start
        rd(3'd0, base);
        low0 = total_low;
        wr(3'd0, 8'h37); wr(3'd0, 8'h6F); wr(3'd0, 8'h0E); wr(3'd0, 8'hF9);
        repeat (20) @(negedge clk);
        check(total_low == low0, "R2 non-start codes keep CS high",
              64'(total_low), 64'(low0));
        rd(3'd0, v);
        check(v == base, "R2 non-start codes leave control", 64'(v), 64'(base));

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule